// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Software configures it through two protected registers and keeps it alive by writing a fixed restart value to a third. If software stops restarting it, the countdown reaches zero and the block signals the fault. It can hold the system reset output high for a chosen number of clock cycles, or it can raise a sticky interrupt.

The configuration registers only accept a write when the written word carries the right key pattern. Stray or runaway writes therefore cannot disable or slow down the timer. The countdown runs from the bus clock through one of four prescaler ratios. Its start value is a coarse 12-bit reload field that fills the top bits of the counter, with the low bits starting at zero.

Top module: `wdog_keyed`

## Requirements
- R1: After a synchronous reset, the mode, control and status registers read zero, the watchdog is stopped, and both alarm outputs are low.
- R2: A write to byte offset 0x0 (mode) is stored only when data[23:12] equals 0xABC; any other write there is ignored. The fields are run = bit 0, reset-enable = bit 1, interrupt-enable = bit 2 and pulse-length code = bits [5:4]. A read returns these fields with every other bit zero.
- R3: A write to offset 0x4 (control) is stored only when data[31:16] equals 0x0092. The fields are reload = bits [13:2] and prescaler select = bits [1:0]. A read returns only these fields.
- R4: A write of exactly 0x00001999 to offset 0x8 reloads the counter and restarts the prescaler phase. Any other value written there is ignored, and offset 0x8 reads as zero.
- R5: The prescaler divides the bus clock by 8, 64, 512 or 4096 for select values 0, 1, 2 and 3.
- R6: The counter starts from reload × 2^LOW_W and decrements once per prescaler tick. Expiry happens on the first tick that finds the counter at zero, which is divisor × (reload × 2^LOW_W + 1) clock edges after the restart edge.
- R7: While the run bit is clear, the counter and the prescaler hold their values. Expiry is delayed by exactly the number of clock edges for which the watchdog was stopped.
- R8: Status bit 0 (offset 0xC) is set on expiry and cleared by a valid restart.
- R9: If reset-enable is set, expiry drives the reset output high for 2 << code cycles (2, 4, 8, 16). If reset-enable is clear, the reset output stays low.
- R10: If interrupt-enable is set, expiry raises the interrupt output, which stays high until a valid restart. If interrupt-enable is clear, the interrupt output stays low.
- R11: A reload value of zero expires on the first prescaler tick after a restart.
- R12: Only one expiry occurs per restart. After it, no further reset pulse is produced and the status stays set, however long the block runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, registered one cycle after the address |
| wdt_rst_o | output | 1 | Reset pulse on expiry |
| wdt_irq_o | output | 1 | Sticky interrupt on expiry |

## Verification
The hardest situation to reach from the ports is a stopped interval in the middle of a countdown, where both the counter and the prescaler phase must freeze. The stimulus restarts the timer, uses key-correct mode writes to clear and then set the run bit, and records the clock edge of each write. It then requires expiry to move later by exactly the stopped span. Single expiry is reached by letting the block run hundreds of cycles past a timeout with no restart, and by confirming that no second pulse appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [15:0] CTRL_KEY = 16'h0092;
  localparam logic [31:0] KICK_KEY = 32'h0000_1999;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } mode_t;

  typedef struct packed {
    logic [11:0] reload;
    logic [1:0]  psel;
  } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              expired,
  output mode_t             mode_q,
  output ctrl_t             ctrl_q,
  output logic              kick,
  output logic [31:0]       rd_data
);

  localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_KICK = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12);

  logic        hit_mode, hit_ctrl, hit_kick;
  logic        mode_ok, ctrl_ok;
  logic [31:0] rd_next;

  assign hit_mode = wr_en && (addr == OFF_MODE);
  assign hit_ctrl = wr_en && (addr == OFF_CTRL);
  assign hit_kick = wr_en && (addr == OFF_KICK);

  assign mode_ok = hit_mode && (wr_data[23:12] == MODE_KEY);
  assign ctrl_ok = hit_ctrl && (wr_data[31:16] == CTRL_KEY);
  assign kick    = hit_kick && (wr_data == KICK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (mode_ok) begin
      mode_q.plen   <= wr_data[5:4];
      mode_q.irq_en <= wr_data[2];
      mode_q.rst_en <= wr_data[1];
      mode_q.run    <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_ok) begin
      ctrl_q.reload <= wr_data[13:2];
      ctrl_q.psel   <= wr_data[1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == OFF_MODE)
      rd_next = {26'b0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.run};
    else if (addr == OFF_CTRL)
      rd_next = {18'b0, ctrl_q.reload, ctrl_q.psel};
    else if (addr == OFF_STAT)
      rd_next = {31'b0, expired};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R2: a mode write without the key leaves the mode fields untouched
  p_mode_key_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_mode && (wr_data[23:12] != MODE_KEY)) |=> $stable(mode_q));

  // R3: a control write without the key leaves the control fields untouched
  p_ctrl_key_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_ctrl && (wr_data[31:16] != CTRL_KEY)) |=> $stable(ctrl_q));

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int BASE_LOG = 3,
  parameter int STEP_LOG = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] psel,
  output logic       tick
);

  localparam int W = BASE_LOG + 3 * STEP_LOG;

  logic [W-1:0] cnt_q;
  logic [W-1:0] last;
  int unsigned  shamt;

  always_comb begin
    shamt = BASE_LOG + STEP_LOG * int'(psel);
    last  = W'((64'd1 << shamt) - 64'd1);
  end

  assign tick = run && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + W'(1);
  end

  // R7: the divider phase is frozen while stopped
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int RELOAD_W = 12,
  parameter int LOW_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                kick,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire,
  output logic                expired_q
);

  localparam int CNT_W = RELOAD_W + LOW_W;

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = run && tick;
  assign expire = step && (cnt_q == '0) && !expired_q && !kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (kick) begin
      cnt_q     <= {reload, {LOW_W{1'b0}}};
      expired_q <= 1'b0;
    end else begin
      if (step && (cnt_q != '0)) cnt_q <= cnt_q - CNT_W'(1);
      if (expire) expired_q <= 1'b1;
    end
  end

  // R7: the prescaler never ticks while the watchdog is stopped
  p_tick_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  // R8: a valid restart clears the status and loads the counter
  p_kick_load_r8: assert property (@(posedge clk) disable iff (rst)
    kick |=> (!expired_q && (cnt_q == {$past(reload), {LOW_W{1'b0}}})));

  // R12: once expired, the flag stays until the next restart
  p_single_r12: assert property (@(posedge clk) disable iff (rst)
    (expired_q && !kick) |=> expired_q);

endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm #(
  parameter int LEN_BASE_LOG = 1,
  parameter int LEN_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic             kick,
  input  logic             rst_en,
  input  logic             irq_en,
  input  logic [LEN_W-1:0] plen,
  output logic             rst_o,
  output logic             irq_o
);

  localparam int PW = LEN_BASE_LOG + (1 << LEN_W);

  logic [PW-1:0] left_q;
  logic [PW-1:0] span_m1;

  always_comb
    span_m1 = (PW'(1) << (LEN_BASE_LOG + int'(plen))) - PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_o  <= 1'b0;
      left_q <= '0;
    end else if (expire && rst_en) begin
      rst_o  <= 1'b1;
      left_q <= span_m1;
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
    end else begin
      rst_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   irq_o <= 1'b0;
    else if (kick)             irq_o <= 1'b0;
    else if (expire && irq_en) irq_o <= 1'b1;
  end

  // R9: a reset pulse only starts from an expiry
  p_pulse_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> $past(expire));

  // R10: the interrupt is sticky until a restart
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !kick) |=> irq_o);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int LOW_W        = 12,
  parameter int PRE_BASE_LOG = 3,
  parameter int PRE_STEP_LOG = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);

  localparam int RELOAD_W = 12;

  mode_t mode_q;
  ctrl_t ctrl_q;
  logic  kick, tick, expire, expired_q;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk_i),
    .rst     (rst_i),
    .addr    (addr_i),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .expired (expired_q),
    .mode_q  (mode_q),
    .ctrl_q  (ctrl_q),
    .kick    (kick),
    .rd_data (rd_data_o)
  );

  wdog_prescale #(.BASE_LOG(PRE_BASE_LOG), .STEP_LOG(PRE_STEP_LOG)) u_pre (
    .clk   (clk_i),
    .rst   (rst_i),
    .run   (mode_q.run),
    .clear (kick),
    .psel  (ctrl_q.psel),
    .tick  (tick)
  );

  wdog_count #(.RELOAD_W(RELOAD_W), .LOW_W(LOW_W)) u_cnt (
    .clk       (clk_i),
    .rst       (rst_i),
    .run       (mode_q.run),
    .kick      (kick),
    .tick      (tick),
    .reload    (ctrl_q.reload),
    .expire    (expire),
    .expired_q (expired_q)
  );

  wdog_alarm #(.LEN_BASE_LOG(1), .LEN_W(2)) u_alarm (
    .clk    (clk_i),
    .rst    (rst_i),
    .expire (expire),
    .kick   (kick),
    .rst_en (mode_q.rst_en),
    .irq_en (mode_q.irq_en),
    .plen   (mode_q.plen),
    .rst_o  (wdt_rst_o),
    .irq_o  (wdt_irq_o)
  );

endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wdt_rst, wdt_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_keyed #(.ADDR_W(4), .LOW_W(2)) uut (
    .clk_i     (clk),
    .rst_i     (rst),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .wdt_rst_o (wdt_rst),
    .wdt_irq_o (wdt_irq)
  );

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against queued expectations
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    e = cyc;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wait_rise(input bit use_irq, output int e);
    e = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ((use_irq ? wdt_irq : wdt_rst) == 1'b1) begin
        e = cyc;
        break;
      end
    end
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (wdt_rst) w++;
      else break;
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0, e1, ed, ee, er, w, hits;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rst out", wdt_rst, 0);
    check("R1 irq out", wdt_irq, 0);
    rd(4'h0, 32'h0, "R1 mode");
    rd(4'h4, 32'h0, "R1 ctrl");
    rd(4'hC, 32'h0, "R1 status");

    // R2 key gate on mode, R3 key gate on control
    wr(4'h0, 32'h00ABD033, e0);
    rd(4'h0, 32'h0, "R2 bad key ignored");
    wr(4'h0, 32'hFFABC032, e0);
    rd(4'h0, 32'h32, "R2 fields, key reads zero");
    wr(4'h4, 32'h00930008, e0);
    rd(4'h4, 32'h0, "R3 bad key ignored");
    wr(4'h4, 32'h0092C008, e0);
    rd(4'h4, 32'h8, "R3 fields only");

    // R6 timing, R9 length 16, R4 non-key restart ignored
    wr(4'h0, 32'h00ABC033, e0);
    wr(4'h8, 32'h00001999, e0);
    repeat (30) @(negedge clk);
    wr(4'h8, 32'h00001998, e1);
    rd(4'h8, 32'h0, "R4 restart reads zero");
    wait_rise(1'b0, er);
    check("R6 R4 expiry edge", er - e0, 72);
    pulse_width(w);
    check("R9 pulse 16", w, 16);
    check("R10 irq off when disabled", wdt_irq, 0);
    rd(4'hC, 32'h1, "R8 status set");

    // R12 single expiry
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wdt_rst) hits++;
    end
    check("R12 no second pulse", hits, 0);
    rd(4'hC, 32'h1, "R12 status stays");

    // R8 clear, R4 restart while running postpones
    wr(4'h8, 32'h00001999, e0);
    rd(4'hC, 32'h0, "R8 status cleared");
    repeat (40) @(negedge clk);
    wr(4'h8, 32'h00001999, e1);
    wait_rise(1'b0, er);
    check("R4 restart postpones", er - e1, 72);
    pulse_width(w);

    // R7 stopped span delays expiry
    wr(4'h8, 32'h00001999, e0);
    repeat (20) @(negedge clk);
    wr(4'h0, 32'h00ABC032, ed);
    repeat (50) @(negedge clk);
    wr(4'h0, 32'h00ABC033, ee);
    wait_rise(1'b0, er);
    check("R7 hold while stopped", er - e0, 72 + (ee - ed));
    pulse_width(w);

    // R9 length code 0
    wr(4'h0, 32'h00ABC003, e1);
    wr(4'h8, 32'h00001999, e0);
    wait_rise(1'b0, er);
    check("R9 expiry len0", er - e0, 72);
    pulse_width(w);
    check("R9 pulse 2", w, 2);

    // R5 divide by 64, reload 1
    wr(4'h4, 32'h00920005, e1);
    wr(4'h8, 32'h00001999, e0);
    wait_rise(1'b0, er);
    check("R5 div64", er - e0, 320);
    pulse_width(w);

    // R11 reload zero, divide by 8
    wr(4'h4, 32'h00920000, e1);
    wr(4'h8, 32'h00001999, e0);
    wait_rise(1'b0, er);
    check("R11 reload zero", er - e0, 8);
    pulse_width(w);

    // R5 divide by 512 and 4096, reload zero
    wr(4'h4, 32'h00920002, e1);
    wr(4'h8, 32'h00001999, e0);
    wait_rise(1'b0, er);
    check("R5 div512", er - e0, 512);
    pulse_width(w);
    wr(4'h4, 32'h00920003, e1);
    wr(4'h8, 32'h00001999, e0);
    wait_rise(1'b0, er);
    check("R5 div4096", er - e0, 4096);
    pulse_width(w);

    // R10 interrupt routing
    wr(4'h0, 32'h00ABC005, e1);
    wr(4'h4, 32'h00920008, e1);
    wr(4'h8, 32'h00001999, e0);
    wait_rise(1'b1, er);
    check("R10 irq expiry", er - e0, 72);
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wdt_rst) hits++;
    end
    check("R9 no pulse when disabled", hits, 0);
    check("R10 irq sticky", wdt_irq, 1);
    wr(4'h8, 32'h00001999, e0);
    check("R10 irq cleared by restart", wdt_irq, 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule